// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address of every beat of one read or write burst on a memory with row and column addressing. A single-cycle start strobe captures a starting column, a 3-bit length code and an order bit. From the next clock on, the block presents one column per clock together with a valid flag. A last flag marks the final beat of a fixed-length burst.

Fixed bursts of 2, 4 or 8 beats stay inside an aligned block of that size. The upper column bits are held and only the low bits move. Those low bits either count upward modulo the block size (sequential) or follow the start XORed with the beat number (interleaved). A full-page burst walks the whole row and wraps from the highest column to column 0. It runs until a stop input ends it. A stop input can also cut a fixed burst short. A fresh start strobe abandons any burst in progress.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `valid` and `last` are low.
- R2: When `start` is sampled high with a legal code, `valid` is high from the next clock and the first beat's `col` equals the sampled `start_col`.
- R3: Length code 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives an unbounded full page. Each beat lasts exactly one clock.
- R4: With `interleave` = 0 and a fixed length L, beat k has column bits above log2(L) equal to the start's, and low bits equal to (start + k) mod L. For example, L = 4 from 1 gives 1,2,3,0.
- R5: With `interleave` = 1 and a fixed length L, beat k has the same upper bits, and low bits equal to (start XOR k) within L. For example, L = 8 from 5 gives 5,4,7,6,1,0,3,2.
- R6: With length code 000, `interleave` has no effect and the single beat is `start_col`.
- R7: A full-page burst steps the column by one each clock and wraps from 2^COL_W-1 to 0. It continues until stopped and never raises `last`.
- R8: `last` is high only on the final beat of a fixed-length burst. On the following clock `valid` is low unless a new burst starts.
- R9: `stop` sampled high during a burst makes `valid` low from the next clock. When idle, `stop` has no effect.
- R10: A legal `start` during a burst restarts from the new column on the next clock.
- R11: A `start` with a reserved code is ignored, and the current burst or idle state continues unchanged. The reserved codes are 100 to 110 in either order, and 111 when `interleave` = 1.
- R12: When a legal `start` and `stop` are sampled together, the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst with the inputs below |
| start_col | input | COL_W | Starting column |
| len_code | input | 3 | Burst length code |
| interleave | input | 1 | 1 selects interleaved order |
| stop | input | 1 | End the burst in progress |
| valid | output | 1 | A beat is presented on `col` |
| col | output | COL_W | Column of the current beat |
| last | output | 1 | Final beat of a fixed-length burst |

## Verification
Sequential and interleaved bursts start at non-zero offsets inside blocks whose upper bits are non-zero. This separates wrap-inside-block behaviour from plain incrementing, and XOR order from additive order. A single-beat burst with the order bit set shows that the bit is ignored. A full page starting just below the top column exposes the row wrap. Stop, restart, reserved codes and a start colliding with a stop are each applied both mid-burst and while idle, so that the priority among them can be observed at the outputs.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             interleave,
  input  logic             stop,
  output logic             valid,
  output logic [COL_W-1:0] col,
  output logic             last
);
  localparam int CW = COL_W;

  logic          act;
  logic [CW-1:0] base;
  logic [CW-1:0] cnt;
  logic [2:0]    code;
  logic          ilv;
  logic [CW-1:0] mask;

  wire legal = !len_code[2] || (len_code == 3'b111 && !interleave);
  wire go    = start && legal;
  wire full  = (code == 3'b111);

  always_comb begin
    case (code)
      3'b000:  mask = '0;
      3'b001:  mask = CW'(1);
      3'b010:  mask = CW'(3);
      3'b011:  mask = CW'(7);
      default: mask = '1;
    endcase
  end

  wire [CW-1:0] pos = ilv ? (base ^ cnt) : (base + cnt);

  assign col   = (base & ~mask) | (pos & mask);
  assign last  = act && !full && (cnt == mask);
  assign valid = act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act  <= 1'b0;
      base <= '0;
      cnt  <= '0;
      code <= 3'b000;
      ilv  <= 1'b0;
    end else if (go) begin
      act  <= 1'b1;
      base <= start_col;
      cnt  <= '0;
      code <= len_code;
      ilv  <= interleave;
    end else if (act) begin
      if (stop || last) act <= 1'b0;
      else              cnt <= cnt + 1'b1;
    end
  end

  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid); // R8
  AST_LAST_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !go) |=> !valid); // R8
  AST_NO_LAST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && full) |-> !last); // R7
  AST_START_COL: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (valid && col == $past(start_col))); // R2
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && stop && !go) |=> !valid); // R9
  AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !full && !last && !stop && !go) |=>
      ((col & ~mask) == $past(col & ~mask))); // R4
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !go) |=> !valid); // R11
endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  localparam int W = 10;
  localparam int NCOL = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] start_col = '0;
  logic [2:0]   len_code = 3'b000;
  logic         interleave = 1'b0;
  logic         stop = 1'b0;
  logic         valid;
  logic [W-1:0] col;
  logic         last;

  int checks = 0;
  int errors = 0;

  int m_act = 0, m_base = 0, m_cnt = 0, m_len = 1, m_il = 0;

  always #5 clk = ~clk;

  burst_col_seq #(.COL_W(W)) u_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .interleave(interleave), .stop(stop),
    .valid(valid), .col(col), .last(last)
  );

  function automatic int code_len(input int c);
    case (c)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return -1;
    endcase
  endfunction

  function automatic int exp_col();
    int off, blk, k;
    if (m_len == 0) return (m_base + m_cnt) % NCOL;
    off = m_base % m_len;
    blk = m_base - off;
    if (m_il != 0) k = off ^ m_cnt;
    else           k = (off + m_cnt) % m_len;
    return blk + k;
  endfunction

  task automatic check(input string tag, input string what, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act_v, exp_v, $time);
    end
  endtask

  task automatic step(input string tag, input bit s, input int c, input int code,
                      input bit il, input bit stp);
    int l;
    bit ok;
    start = s; start_col = W'(c); len_code = 3'(code); interleave = il; stop = stp;
    @(posedge clk);
    l = code_len(code);
    ok = (l >= 0) && !(l == 0 && il);
    if (s && ok) begin
      m_act = 1; m_base = c; m_cnt = 0; m_len = l; m_il = il;
    end else if (m_act != 0) begin
      if (stp || (m_len != 0 && m_cnt == m_len - 1)) m_act = 0;
      else m_cnt = (m_cnt + 1) % NCOL;
    end
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    check(tag, "valid", int'(valid), m_act);
    if (m_act != 0) check(tag, "col", int'(col), exp_col());
    check(tag, "last", int'(last), (m_act != 0 && m_len != 0 && m_cnt == m_len - 1) ? 1 : 0);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 0, 0, 1'b0, 1'b0);
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", "valid", int'(valid), 0);
    check("R1", "last", int'(last), 0);

    // R2 R4: sequential 4 from column 0x2A1, runs 1,2,3,0 in its block
    step("R2", 1'b1, 'h2A1, 2, 1'b0, 1'b0);
    idle("R4", 5);
    // R3: sequential 2 and 8
    step("R3", 1'b1, 'h133, 1, 1'b0, 1'b0);
    idle("R3", 3);
    step("R3", 1'b1, 'h0FE, 3, 1'b0, 1'b0);
    idle("R3", 9);
    // R5: interleaved 8 from 5, interleaved 4 from 2
    step("R5", 1'b1, 'h1D5, 3, 1'b1, 1'b0);
    idle("R5", 9);
    step("R5", 1'b1, 'h33E, 2, 1'b1, 1'b0);
    idle("R5", 5);
    // R6: single beat, order bit set
    step("R6", 1'b1, 'h157, 0, 1'b1, 1'b0);
    idle("R8", 2);
    // R7: full page near the top of the row, wraps, then stop
    step("R7", 1'b1, NCOL - 3, 7, 1'b0, 1'b0);
    idle("R7", 8);
    step("R9", 1'b0, 0, 0, 1'b0, 1'b1);
    idle("R9", 2);
    // R9: stop while idle, then stop cutting a fixed burst
    step("R9", 1'b0, 0, 0, 1'b0, 1'b1);
    step("R9", 1'b1, 'h040, 3, 1'b0, 1'b0);
    idle("R9", 2);
    step("R9", 1'b0, 0, 0, 1'b0, 1'b1);
    idle("R9", 2);
    // R10: restart mid burst
    step("R10", 1'b1, 'h080, 3, 1'b0, 1'b0);
    idle("R10", 3);
    step("R10", 1'b1, 'h3F9, 2, 1'b1, 1'b0);
    idle("R10", 5);
    // R11: reserved codes while idle and mid burst
    step("R11", 1'b1, 'h111, 5, 1'b0, 1'b0);
    idle("R11", 1);
    step("R11", 1'b1, 'h222, 3, 1'b0, 1'b0);
    idle("R11", 2);
    step("R11", 1'b1, 'h010, 7, 1'b1, 1'b0);
    step("R11", 1'b1, 'h010, 4, 1'b0, 1'b0);
    step("R11", 1'b1, 'h010, 6, 1'b1, 1'b0);
    idle("R11", 6);
    // R12: start and stop together, mid burst and idle
    step("R12", 1'b1, 'h300, 7, 1'b0, 1'b0);
    idle("R12", 2);
    step("R12", 1'b1, 'h205, 2, 1'b0, 1'b1);
    idle("R12", 4);
    step("R12", 1'b1, 'h0C6, 1, 1'b1, 1'b1);
    idle("R12", 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule